// File: doc/BRIEF.md
# Sawtooth Tile Scan Sequencer

This block drives the loop schedule of a tiled attention engine. After a start command it walks every query tile in turn and, for each one, visits every key/value tile. Each key/value visit is broken into four datapath steps: fetch the tile, compute scores, refresh the running softmax statistics, and accumulate the weighted values. Once the last key/value tile of a query tile has finished its accumulate step, one extra write-back step is issued for that query tile. Every step is offered on a valid/ready handshake and advances only when the downstream datapath accepts it.

A mode input chooses the inner scan order. The plain order runs the key/value index upward on every query tile. The sawtooth order runs it upward on even query tiles and downward on odd ones. Consecutive query tiles then meet the same key/value tiles close together in time, which roughly halves the reuse distance seen by a shared cache. Both tile counts are runtime values captured when a job starts, and a one-cycle done pulse marks the end of the job.

Top module: `kv_sweep_sequencer`

## Requirements
- R1: When idle, a `start` pulse with valid counts captures `q_count`, `kv_count` and `order_sel`. From the next cycle `step_valid` is high and the first step shows q_idx 0, kv_idx 0 and phase 0. Later changes on those inputs have no effect on the running job.
- R2: A count is valid when it lies in 1..65536. A `start` with either count at 0 or above 65536 is ignored: `step_valid` and `done` stay low.
- R3: Each key/value visit presents `step_phase` values 0 (load), 1 (score), 2 (statistics update) and 3 (value accumulate), in that order, with `q_idx` and `kv_idx` unchanged.
- R4: With `order_sel` = 0, kv_idx runs 0, 1, ..., N_KV-1 on every query tile.
- R5: With `order_sel` = 1, kv_idx runs 0 up to N_KV-1 on even query tiles and N_KV-1 down to 0 on odd query tiles.
- R6: The accumulate step of the final key/value tile of a query tile is followed by exactly one step with `step_phase` = 4 (write-back). It carries that query tile's index and the final kv_idx.
- R7: Query tiles are served in order 0..N_Q-1. All key/value steps and the write-back of one query tile come before any step of the next.
- R8: A step advances only on a cycle with `step_valid` and `step_ready` both high. While `step_ready` is low, `step_valid`, `step_phase`, `q_idx` and `kv_idx` hold.
- R9: `done` is high for exactly one cycle, in the cycle after the write-back of the last query tile is accepted. `step_valid` is low in that cycle, and the block is idle afterwards.
- R10: A `start` that arrives while a job is running is ignored.
- R11: With N_KV = 1, both orders give kv_idx 0 for every step of every query tile.
- R12: While `rst_n` is low, and in the cycle after it is released, `step_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a job when idle |
| order_sel | input | 1 | 0 = plain ascending scan, 1 = sawtooth scan |
| q_count | input | 17 | Number of query tiles, 1..65536 |
| kv_count | input | 17 | Number of key/value tiles, 1..65536 |
| step_ready | input | 1 | Datapath accepts the offered step |
| step_valid | output | 1 | A step is offered |
| step_phase | output | 3 | 0 load, 1 score, 2 statistics, 3 accumulate, 4 write-back |
| q_idx | output | 16 | Query tile index of the offered step |
| kv_idx | output | 16 | Key/value tile index of the offered step |
| done | output | 1 | One-cycle job completion pulse |

## Verification
The hardest situations to reach are stalls that land on row boundaries: the accumulate-to-write-back turn and the write-back-to-next-row turn, where a descending row restarts at N_KV-1. The bench holds `step_ready` low on a repeating one-in-three pattern across whole sawtooth jobs, so stalls fall on every phase, including those turns. It checks that the held step does not move and that the next row starts at the right end. A start command raised during the first held step of a job, with different counts and the opposite order, exercises the rule that a running job ignores start.

// File: rtl/kv_sweep_pkg.sv
// Shared types for the key/value tile scan sequencer.
// Assumes: phase codes are visible on the step_phase port and decoded by
// the downstream datapath, so their values are fixed.
package kv_sweep_pkg;

    // Step kinds offered to the datapath; values are part of the port contract.
    typedef enum logic [2:0] {
        PH_LOAD  = 3'd0,
        PH_SCORE = 3'd1,
        PH_STATS = 3'd2,
        PH_ACCUM = 3'd3,
        PH_WBACK = 3'd4
    } sweep_phase_t;

    // Job-level control state.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } sweep_state_t;

endpackage

// File: rtl/kv_sweep_outer.sv
// Query tile counter.
// Counts from 0 to last_idx, one step per advance. Assumes init and advance
// are never high together and that last_idx is stable while counting.
module kv_sweep_outer #(
    parameter int IDX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             advance,
    input  logic [IDX_W-1:0] last_idx,
    output logic [IDX_W-1:0] idx,
    output logic             at_end
);

    // Holds the current query tile index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (init) begin
            idx <= '0;
        end else if (advance) begin
            idx <= idx + 1'b1;
        end
    end

    // Flags the final query tile of the job.
    always_comb begin
        at_end = (idx == last_idx);
    end

    // Counting never runs past the final tile.
    AST_OUTER_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> !at_end); // R7

endmodule

// File: rtl/kv_sweep_inner.sv
// Key/value tile index generator with selectable direction.
// On init the index is placed at the start of a row (0 when ascending,
// last_idx when descending). Each advance moves one step in the row's
// direction. Assumes desc stays constant over a row and that advance is
// never requested at the row's end.
module kv_sweep_inner #(
    parameter int IDX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             init_desc,
    input  logic             advance,
    input  logic             desc,
    input  logic [IDX_W-1:0] last_idx,
    output logic [IDX_W-1:0] idx,
    output logic             at_end
);

    logic [IDX_W-1:0] row_first;
    logic [IDX_W-1:0] stepped;

    // Picks the first index of the row about to begin.
    always_comb begin
        row_first = init_desc ? last_idx : '0;
    end

    // Computes the neighbour index in the current direction.
    always_comb begin
        stepped = desc ? (idx - 1'b1) : (idx + 1'b1);
    end

    // Holds the current key/value tile index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (init) begin
            idx <= row_first;
        end else if (advance) begin
            idx <= stepped;
        end
    end

    // Flags the final tile of the row for the current direction.
    always_comb begin
        at_end = desc ? (idx == '0) : (idx == last_idx);
    end

    // The index never steps past either end of a row.
    AST_INNER_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> !at_end); // R4

endmodule

// File: rtl/kv_sweep_phase.sv
// Step phase stepper for one key/value visit.
// Walks load, score, statistics and accumulate on accepted steps. After
// accumulate it goes to write-back when row_end is set, else back to load.
// Write-back returns to load. Assumes clear is only raised outside a job.
module kv_sweep_phase
    import kv_sweep_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         fire,
    input  logic         row_end,
    output sweep_phase_t phase
);

    sweep_phase_t phase_nxt;

    // Chooses the phase that follows an accepted step.
    always_comb begin
        unique case (phase)
            PH_LOAD:  phase_nxt = PH_SCORE;
            PH_SCORE: phase_nxt = PH_STATS;
            PH_STATS: phase_nxt = PH_ACCUM;
            PH_ACCUM: phase_nxt = row_end ? PH_WBACK : PH_LOAD;
            default:  phase_nxt = PH_LOAD;
        endcase
    end

    // Holds the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_LOAD;
        end else if (clear) begin
            phase <= PH_LOAD;
        end else if (fire) begin
            phase <= phase_nxt;
        end
    end

    // A load is always followed by a score step.
    AST_LOAD_THEN_SCORE: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !clear && phase == PH_LOAD) |=> phase == PH_SCORE); // R3
    // Statistics update is always followed by accumulate.
    AST_STATS_THEN_ACCUM: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !clear && phase == PH_STATS) |=> phase == PH_ACCUM); // R3
    // Phase code never leaves the defined set.
    AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        phase inside {PH_LOAD, PH_SCORE, PH_STATS, PH_ACCUM, PH_WBACK}); // R3

endmodule

// File: rtl/kv_sweep_sequencer.sv
// Key/value tile scan sequencer (top).
// Captures the job parameters on start, then offers one step per cycle on
// a valid/ready handshake: four phases per key/value tile, one write-back
// per query tile, and a done pulse at the end. order_sel = 1 reverses the
// inner scan on odd query tiles. Assumes step_ready may be driven at any
// time; counts outside 1..2**IDX_W are refused.
module kv_sweep_sequencer
    import kv_sweep_pkg::*;
#(
    parameter int IDX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             order_sel,
    input  logic [IDX_W:0]   q_count,
    input  logic [IDX_W:0]   kv_count,
    input  logic             step_ready,
    output logic             step_valid,
    output logic [2:0]       step_phase,
    output logic [IDX_W-1:0] q_idx,
    output logic [IDX_W-1:0] kv_idx,
    output logic             done
);

    localparam logic [IDX_W:0] MAX_COUNT = {1'b1, {IDX_W{1'b0}}};

    sweep_state_t     state;
    sweep_phase_t     phase;
    logic             sawtooth_r;
    logic [IDX_W-1:0] q_last_r;
    logic [IDX_W-1:0] kv_last_r;
    logic             counts_ok;
    logic             launch;
    logic             fire;
    logic             q_end;
    logic             kv_end;
    logic             row_desc;
    logic             next_row_desc;
    logic             kv_step;
    logic             row_close;
    logic             next_row;
    logic             job_close;
    logic             kv_init;

    // Checks that both requested counts are within the supported range.
    always_comb begin
        counts_ok = (q_count != '0) && (q_count <= MAX_COUNT) &&
                    (kv_count != '0) && (kv_count <= MAX_COUNT);
    end

    // Decodes the control events of this cycle.
    always_comb begin
        launch        = (state == ST_IDLE) && start && counts_ok;
        fire          = (state == ST_RUN) && step_ready;
        kv_step       = fire && (phase == PH_ACCUM) && !kv_end;
        row_close     = fire && (phase == PH_WBACK);
        next_row      = row_close && !q_end;
        job_close     = row_close && q_end;
        row_desc      = sawtooth_r && q_idx[0];
        next_row_desc = sawtooth_r && !q_idx[0];
        kv_init       = launch || next_row;
    end

    // Captures the job parameters when a job is launched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sawtooth_r <= 1'b0;
            q_last_r   <= '0;
            kv_last_r  <= '0;
        end else if (launch) begin
            sawtooth_r <= order_sel;
            q_last_r   <= q_count[IDX_W-1:0] - 1'b1;
            kv_last_r  <= kv_count[IDX_W-1:0] - 1'b1;
        end
    end

    // Steps the job-level state: idle, running, done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (launch)    state <= ST_RUN;
                ST_RUN:  if (job_close) state <= ST_DONE;
                default:                state <= ST_IDLE;
            endcase
        end
    end

    kv_sweep_outer #(.IDX_W(IDX_W)) u_outer (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (launch),
        .advance  (next_row),
        .last_idx (q_last_r),
        .idx      (q_idx),
        .at_end   (q_end)
    );

    kv_sweep_inner #(.IDX_W(IDX_W)) u_inner (
        .clk       (clk),
        .rst_n     (rst_n),
        .init      (kv_init),
        .init_desc (next_row_desc && !launch),
        .advance   (kv_step),
        .desc      (row_desc),
        .last_idx  (kv_last_r),
        .idx       (kv_idx),
        .at_end    (kv_end)
    );

    kv_sweep_phase u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (launch),
        .fire    (fire),
        .row_end (kv_end),
        .phase   (phase)
    );

    // Drives the port view of the step and completion signals.
    always_comb begin
        step_valid = (state == ST_RUN);
        step_phase = phase;
        done       = (state == ST_DONE);
    end

    // A held step keeps its whole content.
    AST_HOLD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && !step_ready) |=> (step_valid && $stable(step_phase) &&
        $stable(q_idx) && $stable(kv_idx))); // R8
    // Write-back only appears at the end of a row.
    AST_WBACK_AT_ROW_END: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && phase == PH_WBACK) |-> kv_end); // R6
    // The done pulse lasts one cycle and the block is idle after it.
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !step_valid)); // R9
    // On odd rows in sawtooth mode the index walks downward.
    AST_ODD_ROW_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (kv_step && sawtooth_r && q_idx[0]) |=> kv_idx == $past(kv_idx) - 1'b1); // R5
    // In plain mode each new row starts at index zero.
    AST_PLAIN_ROW_START: assert property (@(posedge clk) disable iff (!rst_n)
        (next_row && !sawtooth_r) |=> kv_idx == '0); // R4
    // Index stays inside the captured count during a job.
    AST_KV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid |-> kv_idx <= kv_last_r); // R2

endmodule

// File: tb/kv_sweep_sequencer_test.sv
module kv_sweep_sequencer_test;

    localparam int IDX_W = 16;
    localparam int NJOB  = 7;
    // Stimulus table: query tiles, key/value tiles, order, stall pattern.
    localparam int T_NQ   [NJOB] = '{3, 3, 4, 2, 2, 5, 1};
    localparam int T_NKV  [NJOB] = '{4, 4, 5, 1, 1, 3, 2};
    localparam int T_MODE [NJOB] = '{0, 1, 1, 0, 1, 1, 1};
    localparam int T_STALL[NJOB] = '{0, 0, 1, 0, 1, 1, 1};

    logic             clk = 1'b0;
    logic             rst_n;
    logic             start;
    logic             order_sel;
    logic [IDX_W:0]   q_count;
    logic [IDX_W:0]   kv_count;
    logic             step_ready;
    logic             step_valid;
    logic [2:0]       step_phase;
    logic [IDX_W-1:0] q_idx;
    logic [IDX_W-1:0] kv_idx;
    logic             done;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    kv_sweep_sequencer #(.IDX_W(IDX_W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .order_sel  (order_sel),
        .q_count    (q_count),
        .kv_count   (kv_count),
        .step_ready (step_ready),
        .step_valid (step_valid),
        .step_phase (step_phase),
        .q_idx      (q_idx),
        .kv_idx     (kv_idx),
        .done       (done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Offers one expected step; handles stalls and checks hold behaviour.
    task automatic do_step(input int eq, input int ek, input int ep, input bit stall,
                           input string ktag);
        bit fin = 0;
        while (!fin) begin
            step_ready = stall ? ((cyc % 3) != 2) : 1'b1;
            cyc++;
            chk(step_valid == 1'b1, "R8 valid", int'(step_valid), 1);
            if (step_ready) begin
                chk(int'(q_idx) == eq, "R7 q_idx", int'(q_idx), eq);
                chk(int'(kv_idx) == ek, ktag, int'(kv_idx), ek);
                chk(int'(step_phase) == ep, (ep == 4) ? "R6 phase" : "R3 phase",
                    int'(step_phase), ep);
                @(negedge clk);
                fin = 1;
            end else begin
                automatic int hp = int'(step_phase);
                automatic int hk = int'(kv_idx);
                @(negedge clk);
                chk(int'(step_phase) == hp && int'(kv_idx) == hk, "R8 hold",
                    int'(step_phase), hp);
            end
        end
    endtask

    task automatic pulse_start(input int nq, input int nkv, input int mode);
        q_count   = (IDX_W+1)'(nq);
        kv_count  = (IDX_W+1)'(nkv);
        order_sel = mode[0];
        start     = 1'b1;
        @(negedge clk);
        start     = 1'b0;
    endtask

    task automatic run_job(input int nq, input int nkv, input int mode,
                           input bit stall, input bit poke);
        string ktag;
        pulse_start(nq, nkv, mode);
        // R1: inputs changed after launch must not affect the job.
        q_count   = '0;
        kv_count  = 17'd9;
        order_sel = ~mode[0];
        chk(step_valid && q_idx == 0 && kv_idx == 0 && step_phase == 0, "R1 first step",
            int'(step_valid), 1);
        if (poke) begin
            // R10: start while running, with other counts, is ignored.
            start = 1'b1; q_count = 17'd2; kv_count = 17'd7; step_ready = 1'b0;
            @(negedge clk);
            start = 1'b0;
            chk(step_valid && q_idx == 0 && kv_idx == 0 && step_phase == 0,
                "R10 restart ignored", int'(step_phase), 0);
        end
        ktag = (nkv == 1) ? "R11 kv_idx" : (mode != 0 ? "R5 kv_idx" : "R4 kv_idx");
        for (int q = 0; q < nq; q++) begin
            int lastk = 0;
            for (int k = 0; k < nkv; k++) begin
                int ek = (mode != 0 && (q % 2) == 1) ? (nkv - 1 - k) : k;
                lastk = ek;
                for (int p = 0; p < 4; p++) do_step(q, ek, p, stall, ktag);
            end
            do_step(q, lastk, 4, stall, "R6 kv_idx");
        end
        step_ready = 1'b0;
        chk(done == 1'b1, "R9 done high", int'(done), 1);
        chk(step_valid == 1'b0, "R9 valid low", int'(step_valid), 0);
        @(negedge clk);
        chk(done == 1'b0, "R9 done one cycle", int'(done), 0);
        chk(step_valid == 1'b0, "R9 idle", int'(step_valid), 0);
    endtask

    task automatic expect_refused(input int nq, input int nkv);
        pulse_start(nq, nkv, 0);
        for (int i = 0; i < 3; i++) begin
            chk(step_valid == 1'b0 && done == 1'b0, "R2 refused", int'(step_valid), 0);
            @(negedge clk);
        end
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; order_sel = 1'b0;
        q_count = 17'd1; kv_count = 17'd1; step_ready = 1'b0;
        repeat (3) @(negedge clk);
        chk(step_valid == 1'b0 && done == 1'b0, "R12 in reset", int'(step_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(step_valid == 1'b0 && done == 1'b0, "R12 after reset", int'(step_valid), 0);

        for (int j = 0; j < NJOB; j++)
            run_job(T_NQ[j], T_NKV[j], T_MODE[j], T_STALL[j] != 0, 1'b0);

        // R10: start pulse during a running sawtooth job.
        run_job(3, 3, 1, 1'b1, 1'b1);

        // R2: boundary counts refused.
        expect_refused(0, 4);
        expect_refused(3, 0);
        expect_refused(65537, 2);
        expect_refused(2, 65537);

        // R12: reset in the middle of a job returns to idle.
        pulse_start(4, 4, 1);
        step_ready = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(step_valid == 1'b0 && done == 1'b0, "R12 mid-job reset", int'(step_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(step_valid == 1'b0 && done == 1'b0, "R12 idle after reset", int'(step_valid), 0);

        // R1: a fresh job after reset starts cleanly.
        run_job(2, 3, 0, 1'b0, 1'b0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule